// File: doc/BRIEF.md
# Interrupt Vector Ring Writer

This block takes interrupt events from sources inside the chip and turns each one into a 128-bit vector entry. It stores the entries one after another in a circular ring in memory. It uses a simple write port to do this, and it keeps a write pointer that counts in bytes. The host reads the entries out of the ring. The host then tells the block how far it has read by writing a read pointer. When the two pointers are equal, the ring is empty and there is nothing for the host to do.

A small register file controls the block. It holds two enables, the ring size, the ring base address, both pointers, overflow detection and its clear bit, and an optional writeback mirror of the write pointer. When the producer wraps around onto entries the host has not read, the block sets a sticky overflow flag in the top bit of the write-pointer word. It keeps writing anyway, so the oldest entries are overwritten. An interrupt request stays high while there is work for the host.

Events enter through a four-entry FIFO with a ready/valid handshake. While the ring engine is busy with a memory write or a writeback, the producer is held back.

Top module: `ivr_writer`

## Requirements
- R1: After reset, every register reads 0, `irq` is low, `ev_ready` is high and no memory or writeback write is issued.
- R2: A committed entry carries the source id in bits [7:0], the 28-bit source data in [59:32], the ring id in [71:64], the VMID in [79:72] and the PASID in [95:80]. Every other bit is 0.
- R3: Each entry is written to `mem_addr` = base register (address 2) + write pointer. The write pointer is a byte offset that then grows by 16. It reads back at address 3, bits [19:0].
- R4: The ring holds 4 << N bytes, where N is the 5-bit field in bits [5:1] of the ring control register (address 1). Pointers wrap by masking with that size minus 1.
- R5: `irq` is high while both enables are set and either the write pointer differs from the read pointer (address 4) or the overflow flag is set. It drops once the host writes a read pointer equal to the write pointer.
- R6: With overflow detection on (ring control bit 6), a commit whose next write position equals the read pointer sets bit 31 of the write-pointer word. The entry is still written and the read pointer is left alone.
- R7: With ring control bit 6 clear, wrapping onto the read pointer never sets the overflow flag.
- R8: The overflow flag stays set until a ring control write with bit 7 set. That bit reads back as 0.
- R9: When ring control bit 8 is set, each commit is followed one cycle later by a `wb_wr_en` pulse. That pulse carries the updated write-pointer word to the address held at address 5. When bit 8 is clear, no writeback is issued.
- R10: The block runs only when both the global enable (address 0, bit 0) and the ring enable (ring control bit 0) are set. Otherwise both pointers are held at 0, pointer writes are ignored, and accepted events are dropped without any memory write.
- R11: The producer is back-pressured through `ev_ready` when the input FIFO is full. Every accepted event is written in arrival order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ev_valid | input | 1 | Event offered |
| ev_ready | output | 1 | Event accepted this cycle when high with ev_valid |
| ev_src_id | input | 8 | Source id |
| ev_data | input | 28 | Source data |
| ev_ring_id | input | 8 | Ring id |
| ev_vmid | input | 8 | VMID |
| ev_pasid | input | 16 | PASID |
| reg_wr_en | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Registered read data for reg_addr, one cycle later |
| mem_wr_en | output | 1 | Ring entry write strobe |
| mem_addr | output | 32 | Ring entry byte address |
| mem_wdata | output | 128 | Ring entry |
| wb_wr_en | output | 1 | Writeback strobe |
| wb_addr | output | 32 | Writeback byte address |
| wb_wdata | output | 32 | Write-pointer word being mirrored |
| irq | output | 1 | Interrupt request to host |

## Verification
The bench fills a 64-byte ring until the write position lands on the read pointer. A design that compared against the wrong position, or that stopped writing at that point, would show a missing flag in bit 31, a missing entry, or a moved read pointer. It also wraps the pointer past the ring end, so a wrong mask would send the entry outside the ring. It repeats the wrap with detection off, and checks that the clear bit alone removes the flag. It turns the enables off and then writes pointers and sends events, so a design that kept state while disabled would show nonzero pointers or stray memory writes. A burst of events is sent faster than the engine can drain it, so a design that lost or reordered entries under back-pressure would put the wrong data at some address.

// File: rtl/ivr_pkg.sv
package ivr_pkg;
  localparam int ENTRY_W = 128;
  localparam int REG_W   = 32;

  typedef struct packed {
    logic [7:0]  src;
    logic [27:0] data;
    logic [7:0]  ring;
    logic [7:0]  vmid;
    logic [15:0] pasid;
  } ivr_event_t;

  localparam int EVT_W = $bits(ivr_event_t);

  localparam logic [2:0] A_CTRL  = 3'd0;
  localparam logic [2:0] A_RING  = 3'd1;
  localparam logic [2:0] A_BASE  = 3'd2;
  localparam logic [2:0] A_WPTR  = 3'd3;
  localparam logic [2:0] A_RPTR  = 3'd4;
  localparam logic [2:0] A_WBADR = 3'd5;

  localparam int B_RING_EN = 0;
  localparam int B_SIZE_LO = 1;
  localparam int SIZE_W    = 5;
  localparam int B_OVF_DET = 6;
  localparam int B_OVF_CLR = 7;
  localparam int B_WB_EN   = 8;

  function automatic logic [ENTRY_W-1:0] pack_entry(input ivr_event_t e);
    logic [ENTRY_W-1:0] v;
    v = '0;
    v[7:0]   = e.src;
    v[59:32] = e.data;
    v[71:64] = e.ring;
    v[79:72] = e.vmid;
    v[95:80] = e.pasid;
    return v;
  endfunction
endpackage

// File: rtl/ivr_fifo.sv
module ivr_fifo #(
  parameter int W     = 68,
  parameter int DEPTH = 4
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         in_valid,
  output logic         in_ready,
  input  logic [W-1:0] in_data,
  output logic         out_valid,
  input  logic         out_pop,
  output logic [W-1:0] out_data
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  logic [W-1:0]  store [DEPTH];
  logic [AW-1:0] wr_idx, rd_idx;
  logic [AW:0]   count;
  logic          push, pop;

  assign in_ready  = (count != (AW+1)'(DEPTH));
  assign out_valid = (count != '0);
  assign push      = in_valid && in_ready;
  assign pop       = out_pop && out_valid;
  assign out_data  = store[rd_idx];

  always_ff @(posedge clk) begin
    if (push) store[wr_idx] <= in_data;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_idx <= '0;
      rd_idx <= '0;
      count  <= '0;
    end else begin
      if (push) wr_idx <= (wr_idx == AW'(DEPTH-1)) ? '0 : wr_idx + 1'b1;
      if (pop)  rd_idx <= (rd_idx == AW'(DEPTH-1)) ? '0 : rd_idx + 1'b1;
      case ({push, pop})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end

  p_fifo_bound_r11: assert property (@(posedge clk) disable iff (rst)
    count <= (AW+1)'(DEPTH));
  p_fifo_nopush_full_r11: assert property (@(posedge clk) disable iff (rst)
    (count == (AW+1)'(DEPTH) && !pop) |=> count == (AW+1)'(DEPTH));
endmodule

// File: rtl/ivr_regs.sv
module ivr_regs
  import ivr_pkg::*;
#(
  parameter int PTR_W  = 20,
  parameter int ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [2:0]        addr,
  input  logic [REG_W-1:0]  wdata,
  input  logic [REG_W-1:0]  wptr_word,
  input  logic [PTR_W-1:0]  rptr,
  output logic              active,
  output logic [SIZE_W-1:0] size_log2,
  output logic              ovf_det_en,
  output logic              wb_en,
  output logic              ovf_clr,
  output logic [ADDR_W-1:0] base,
  output logic [ADDR_W-1:0] wb_addr,
  output logic              wptr_wr,
  output logic              rptr_wr,
  output logic [PTR_W-1:0]  ptr_wdata,
  output logic [REG_W-1:0]  rdata
);
  logic irq_en, ring_en;
  logic [REG_W-1:0] ring_word, next_rdata;

  assign active    = irq_en && ring_en;
  assign ovf_clr   = wr_en && (addr == A_RING) && wdata[B_OVF_CLR];
  assign wptr_wr   = wr_en && (addr == A_WPTR);
  assign rptr_wr   = wr_en && (addr == A_RPTR);
  assign ptr_wdata = wdata[PTR_W-1:0];

  always_comb begin
    ring_word = '0;
    ring_word[B_RING_EN] = ring_en;
    ring_word[B_SIZE_LO +: SIZE_W] = size_log2;
    ring_word[B_OVF_DET] = ovf_det_en;
    ring_word[B_WB_EN] = wb_en;
  end

  always_comb begin
    case (addr)
      A_CTRL:  next_rdata = {{(REG_W-1){1'b0}}, irq_en};
      A_RING:  next_rdata = ring_word;
      A_BASE:  next_rdata = REG_W'(base);
      A_WPTR:  next_rdata = wptr_word;
      A_RPTR:  next_rdata = REG_W'(rptr);
      A_WBADR: next_rdata = REG_W'(wb_addr);
      default: next_rdata = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      irq_en     <= 1'b0;
      ring_en    <= 1'b0;
      size_log2  <= '0;
      ovf_det_en <= 1'b0;
      wb_en      <= 1'b0;
      base       <= '0;
      wb_addr    <= '0;
      rdata      <= '0;
    end else begin
      rdata <= next_rdata;
      if (wr_en) begin
        case (addr)
          A_CTRL: irq_en <= wdata[0];
          A_RING: begin
            ring_en    <= wdata[B_RING_EN];
            size_log2  <= wdata[B_SIZE_LO +: SIZE_W];
            ovf_det_en <= wdata[B_OVF_DET];
            wb_en      <= wdata[B_WB_EN];
          end
          A_BASE:  base    <= wdata[ADDR_W-1:0];
          A_WBADR: wb_addr <= wdata[ADDR_W-1:0];
          default: ;
        endcase
      end
    end
  end
endmodule

// File: rtl/ivr_engine.sv
module ivr_engine
  import ivr_pkg::*;
#(
  parameter int PTR_W  = 20,
  parameter int ADDR_W = 32
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               active,
  input  logic [SIZE_W-1:0]  size_log2,
  input  logic               ovf_det_en,
  input  logic               wb_en,
  input  logic               ovf_clr,
  input  logic [ADDR_W-1:0]  base,
  input  logic [ADDR_W-1:0]  wb_addr_cfg,
  input  logic               wptr_wr,
  input  logic               rptr_wr,
  input  logic [PTR_W-1:0]   ptr_wdata,
  input  logic               ev_valid,
  input  ivr_event_t         ev,
  output logic               ev_pop,
  output logic               mem_wr_en,
  output logic [ADDR_W-1:0]  mem_addr,
  output logic [ENTRY_W-1:0] mem_wdata,
  output logic               wb_wr_en,
  output logic [ADDR_W-1:0]  wb_addr,
  output logic [REG_W-1:0]   wb_wdata,
  output logic [REG_W-1:0]   wptr_word,
  output logic [PTR_W-1:0]   rptr_o,
  output logic               irq
);
  localparam logic [PTR_W-1:0] STEP = PTR_W'(16);

  logic [PTR_W-1:0] wptr_q, rptr_q, ring_bytes, ptr_mask, align_mask, nxt;
  logic             flag_q, wb_pend, commit;

  assign ring_bytes = PTR_W'(4) << size_log2;
  assign ptr_mask   = ring_bytes - 1'b1;
  assign align_mask = ptr_mask & ~PTR_W'(15);
  assign nxt        = (wptr_q + STEP) & ptr_mask;
  assign ev_pop     = ev_valid && (!active || !wb_pend);
  assign commit     = active && ev_valid && !wb_pend;
  assign wptr_word  = {flag_q, {(REG_W-1-PTR_W){1'b0}}, wptr_q};
  assign rptr_o     = rptr_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      wptr_q    <= '0;
      rptr_q    <= '0;
      wb_pend   <= 1'b0;
      mem_wr_en <= 1'b0;
      mem_addr  <= '0;
      mem_wdata <= '0;
      wb_wr_en  <= 1'b0;
      wb_addr   <= '0;
      wb_wdata  <= '0;
      irq       <= 1'b0;
    end else begin
      mem_wr_en <= 1'b0;
      wb_wr_en  <= 1'b0;
      irq       <= active && ((wptr_q != rptr_q) || flag_q);
      if (!active) begin
        wptr_q  <= '0;
        rptr_q  <= '0;
        wb_pend <= 1'b0;
      end else begin
        if (rptr_wr) rptr_q <= ptr_wdata & align_mask;
        if (wptr_wr) wptr_q <= ptr_wdata & align_mask;
        if (wb_pend) begin
          wb_wr_en <= 1'b1;
          wb_addr  <= wb_addr_cfg;
          wb_wdata <= wptr_word;
          wb_pend  <= 1'b0;
        end else if (ev_valid) begin
          mem_wr_en <= 1'b1;
          mem_addr  <= base + ADDR_W'(wptr_q);
          mem_wdata <= pack_entry(ev);
          wptr_q    <= nxt;
          wb_pend   <= wb_en;
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) flag_q <= 1'b0;
    else if (commit && ovf_det_en && (nxt == rptr_q)) flag_q <= 1'b1;
    else if (ovf_clr) flag_q <= 1'b0;
  end

  p_no_write_off_r10: assert property (@(posedge clk) disable iff (rst)
    mem_wr_en |-> $past(active));
  p_ptr_zero_off_r10: assert property (@(posedge clk) disable iff (rst)
    !active |=> (wptr_q == '0 && rptr_q == '0));
  p_flag_sticky_r8: assert property (@(posedge clk) disable iff (rst)
    (flag_q && !ovf_clr) |=> flag_q);
  p_wb_follows_r9: assert property (@(posedge clk) disable iff (rst)
    wb_wr_en |-> $past(mem_wr_en));
  p_irq_off_r5: assert property (@(posedge clk) disable iff (rst)
    !active |=> !irq);
  p_rptr_kept_r6: assert property (@(posedge clk) disable iff (rst)
    (active && !rptr_wr) |=> $stable(rptr_q));
endmodule

// File: rtl/ivr_writer.sv
module ivr_writer
  import ivr_pkg::*;
#(
  parameter int PTR_W      = 20,
  parameter int ADDR_W     = 32,
  parameter int FIFO_DEPTH = 4
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               ev_valid,
  output logic               ev_ready,
  input  logic [7:0]         ev_src_id,
  input  logic [27:0]        ev_data,
  input  logic [7:0]         ev_ring_id,
  input  logic [7:0]         ev_vmid,
  input  logic [15:0]        ev_pasid,
  input  logic               reg_wr_en,
  input  logic [2:0]         reg_addr,
  input  logic [31:0]        reg_wdata,
  output logic [31:0]        reg_rdata,
  output logic               mem_wr_en,
  output logic [ADDR_W-1:0]  mem_addr,
  output logic [127:0]       mem_wdata,
  output logic               wb_wr_en,
  output logic [ADDR_W-1:0]  wb_addr,
  output logic [31:0]        wb_wdata,
  output logic               irq
);
  ivr_event_t in_ev, q_ev;
  logic [EVT_W-1:0] q_bits;
  logic q_valid, q_pop;
  logic active, ovf_det_en, wb_en, ovf_clr, wptr_wr, rptr_wr;
  logic [SIZE_W-1:0] size_log2;
  logic [ADDR_W-1:0] base, wb_addr_cfg;
  logic [PTR_W-1:0]  ptr_wdata, rptr;
  logic [REG_W-1:0]  wptr_word;

  assign in_ev = '{src: ev_src_id, data: ev_data, ring: ev_ring_id,
                   vmid: ev_vmid, pasid: ev_pasid};
  assign q_ev  = ivr_event_t'(q_bits);

  ivr_fifo #(.W(EVT_W), .DEPTH(FIFO_DEPTH)) u_fifo (
    .clk(clk), .rst(rst),
    .in_valid(ev_valid), .in_ready(ev_ready), .in_data(in_ev),
    .out_valid(q_valid), .out_pop(q_pop), .out_data(q_bits)
  );

  ivr_regs #(.PTR_W(PTR_W), .ADDR_W(ADDR_W)) u_regs (
    .clk(clk), .rst(rst),
    .wr_en(reg_wr_en), .addr(reg_addr), .wdata(reg_wdata),
    .wptr_word(wptr_word), .rptr(rptr),
    .active(active), .size_log2(size_log2), .ovf_det_en(ovf_det_en),
    .wb_en(wb_en), .ovf_clr(ovf_clr), .base(base), .wb_addr(wb_addr_cfg),
    .wptr_wr(wptr_wr), .rptr_wr(rptr_wr), .ptr_wdata(ptr_wdata),
    .rdata(reg_rdata)
  );

  ivr_engine #(.PTR_W(PTR_W), .ADDR_W(ADDR_W)) u_engine (
    .clk(clk), .rst(rst),
    .active(active), .size_log2(size_log2), .ovf_det_en(ovf_det_en),
    .wb_en(wb_en), .ovf_clr(ovf_clr), .base(base), .wb_addr_cfg(wb_addr_cfg),
    .wptr_wr(wptr_wr), .rptr_wr(rptr_wr), .ptr_wdata(ptr_wdata),
    .ev_valid(q_valid), .ev(q_ev), .ev_pop(q_pop),
    .mem_wr_en(mem_wr_en), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .wb_wr_en(wb_wr_en), .wb_addr(wb_addr), .wb_wdata(wb_wdata),
    .wptr_word(wptr_word), .rptr_o(rptr), .irq(irq)
  );
endmodule

// File: tb/ivr_writer_test.sv
module ivr_writer_test;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic ev_valid = 1'b0;
  logic ev_ready;
  logic [7:0] ev_src_id = '0, ev_ring_id = '0, ev_vmid = '0;
  logic [27:0] ev_data = '0;
  logic [15:0] ev_pasid = '0;
  logic reg_wr_en = 1'b0;
  logic [2:0] reg_addr = '0;
  logic [31:0] reg_wdata = '0, reg_rdata;
  logic mem_wr_en, wb_wr_en, irq;
  logic [31:0] mem_addr, wb_addr, wb_wdata;
  logic [127:0] mem_wdata;

  int n_chk = 0, n_fail = 0, cyc = 0;
  logic [31:0]  mw_a [64];
  logic [127:0] mw_d [64];
  logic [31:0]  wb_a [64];
  logic [31:0]  wb_d [64];
  int mw_cnt = 0, wb_cnt = 0;
  logic saw_bp = 1'b0;

  localparam logic [67:0] VECS [3] = '{
    {8'h12, 28'h0ABCDEF, 8'h05, 8'h03, 16'h1234},
    {8'hFF, 28'hFFFFFFF, 8'hFF, 8'hFF, 16'hFFFF},
    {8'h00, 28'h0000001, 8'h80, 8'h00, 16'h8001}
  };

  ivr_writer uut (
    .clk(clk), .rst(rst), .ev_valid(ev_valid), .ev_ready(ev_ready),
    .ev_src_id(ev_src_id), .ev_data(ev_data), .ev_ring_id(ev_ring_id),
    .ev_vmid(ev_vmid), .ev_pasid(ev_pasid), .reg_wr_en(reg_wr_en),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .mem_wr_en(mem_wr_en), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .wb_wr_en(wb_wr_en), .wb_addr(wb_addr), .wb_wdata(wb_wdata), .irq(irq)
  );

  always #4 clk = ~clk;

  always @(negedge clk) begin
    if (!rst) begin
      if (mem_wr_en && mw_cnt < 64) begin
        mw_a[mw_cnt] = mem_addr; mw_d[mw_cnt] = mem_wdata; mw_cnt++;
      end
      if (wb_wr_en && wb_cnt < 64) begin
        wb_a[wb_cnt] = wb_addr; wb_d[wb_cnt] = wb_wdata; wb_cnt++;
      end
    end
  end

  function automatic logic [127:0] expect_entry(input logic [67:0] v);
    logic [127:0] e = '0;
    e[7:0] = v[67:60]; e[59:32] = v[59:32]; e[71:64] = v[31:24];
    e[79:72] = v[23:16]; e[95:80] = v[15:0];
    return e;
  endfunction

  function automatic logic [67:0] gen_vec(input int k);
    return {8'(k + 1), 28'(k * 32'h111), 8'(k), 8'(k * 3), 16'(16'hA000 + k)};
  endfunction

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  task automatic check(input string req, input logic [127:0] act, input logic [127:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic rwr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk); reg_wr_en = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk); reg_wr_en = 1'b0;
  endtask

  task automatic rrd(input logic [2:0] a, output logic [31:0] d);
    @(negedge clk); reg_addr = a;
    @(negedge clk); d = reg_rdata;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic send(input logic [67:0] v);
    @(negedge clk);
    ev_valid = 1'b1;
    {ev_src_id, ev_data, ev_ring_id, ev_vmid, ev_pasid} = v;
    while (!ev_ready) begin saw_bp = 1'b1; @(negedge clk); end
    @(negedge clk);
    ev_valid = 1'b0;
  endtask

  task automatic wait_mw(input int n);
    for (int t = 0; t < 100 && mw_cnt < n; t++) @(negedge clk);
    idle(2);
  endtask

  initial begin
    forever begin
      @(posedge clk); cyc++;
      if (cyc > 100000) begin
        n_chk++; n_fail++;
        $display("FAIL watchdog actual=%0d expected<=100000", cyc);
        summary();
      end
    end
  end

  initial begin
    logic [31:0] rd;
    int m0;
    idle(4);
    @(negedge clk); rst = 1'b0;
    idle(1);
    // R1 reset state
    check("R1 irq", irq, 0);
    check("R1 ev_ready", ev_ready, 1);
    check("R1 mem_wr_en", mem_wr_en, 0);
    rrd(3'd1, rd); check("R1 ring ctrl", rd, 0);
    rrd(3'd3, rd); check("R1 wptr", rd, 0);
    rrd(3'd4, rd); check("R1 rptr", rd, 0);

    // 64-byte ring: N=4, detect, writeback
    rwr(3'd2, 32'h1000);
    rwr(3'd5, 32'h8000);
    rwr(3'd1, 32'h149);
    rwr(3'd0, 32'h1);

    // table walk: R2 R3 R9 R5
    for (int i = 0; i < 3; i++) begin
      send(VECS[i]);
      wait_mw(i + 1);
      check("R3 addr", mw_a[i], 32'h1000 + 16 * i);
      check("R2 entry", mw_d[i], expect_entry(VECS[i]));
      check("R9 wb data", wb_d[i], 16 * (i + 1));
      check("R9 wb addr", wb_a[i], 32'h8000);
      rrd(3'd3, rd); check("R3 wptr", rd, 16 * (i + 1));
      check("R5 irq pending", irq, 1);
    end

    // R5 host catches up
    rwr(3'd4, 32'd48); idle(3);
    check("R5 irq idle", irq, 0);

    // R4 wrap, R6 overflow
    send(VECS[0]); wait_mw(4);
    check("R4 addr before wrap", mw_a[3], 32'h1030);
    rrd(3'd3, rd); check("R4 wrapped wptr", rd, 0);
    for (int k = 0; k < 3; k++) begin send(gen_vec(k)); wait_mw(5 + k); end
    check("R6 overwrite addr", mw_a[6], 32'h1020);
    check("R6 overwrite data", mw_d[6], expect_entry(gen_vec(2)));
    rrd(3'd3, rd); check("R6 flag in wptr", rd, 32'h8000_0030);
    rrd(3'd4, rd); check("R6 rptr untouched", rd, 48);
    check("R9 wb carries flag", wb_d[wb_cnt - 1], 32'h8000_0030);
    check("R5 irq on flag", irq, 1);

    // R8 clear
    rwr(3'd4, 32'd48); idle(2);
    rrd(3'd3, rd); check("R8 flag sticky", rd[31], 1);
    rwr(3'd1, 32'h1C9); idle(2);
    rrd(3'd3, rd); check("R8 flag cleared", rd, 48);
    rrd(3'd1, rd); check("R8 clear reads 0", rd, 32'h149);
    check("R5 irq after clear", irq, 0);

    // R7 detection off
    rwr(3'd1, 32'h109);
    for (int k = 0; k < 4; k++) begin send(gen_vec(k + 4)); wait_mw(8 + k); end
    rrd(3'd3, rd); check("R7 no flag", rd, 48);

    // R9 writeback off
    rwr(3'd1, 32'h049);
    m0 = wb_cnt;
    send(VECS[1]); wait_mw(12);
    check("R9 no writeback", wb_cnt, m0);
    check("R9 addr still written", mw_a[11], 32'h1030);

    // R10 disable
    rwr(3'd0, 32'h0); idle(2);
    rrd(3'd4, rd); check("R10 rptr zeroed", rd, 0);
    rwr(3'd4, 32'd32);
    rrd(3'd4, rd); check("R10 rptr write ignored", rd, 0);
    m0 = mw_cnt;
    send(VECS[2]); idle(10);
    check("R10 event dropped", mw_cnt, m0);
    check("R10 irq off", irq, 0);

    // R11 burst, 256-byte ring
    rwr(3'd1, 32'h14D);
    rwr(3'd0, 32'h1);
    m0 = mw_cnt;
    saw_bp = 1'b0;
    @(negedge clk);
    for (int k = 0; k < 10; k++) begin
      ev_valid = 1'b1;
      {ev_src_id, ev_data, ev_ring_id, ev_vmid, ev_pasid} = gen_vec(k + 20);
      while (!ev_ready) begin saw_bp = 1'b1; @(negedge clk); end
      @(negedge clk);
    end
    ev_valid = 1'b0;
    wait_mw(m0 + 10);
    check("R11 back-pressure seen", saw_bp, 1);
    for (int k = 0; k < 10; k++) begin
      check("R11 order addr", mw_a[m0 + k], 32'h1000 + 16 * k);
      check("R11 order data", mw_d[m0 + k], expect_entry(gen_vec(k + 20)));
    end
    rrd(3'd3, rd); check("R11 final wptr", rd, 160);

    summary();
  end
endmodule